// File: doc/BRIEF.md
# Locked Read-Modify-Write Unit

This unit carries out one atomic read-modify-write operation at a time for a single requesting hardware thread against a shared memory. Atomicity comes from a machine-wide lock. The unit takes that lock, reads the old word and writes the new word while it holds the lock, and then gives the lock back. Other threads stay out of memory for the whole sequence.

The lock may only be taken when no thread holds it and the requester's store buffer has drained. The lock may only be given back once that buffer is empty again. While the unit waits for either condition, it holds its place in the sequence and issues nothing. The store buffer can keep draining in the meantime.

Five operations are supported: increment, add, subtract, exchange and compare-and-swap. Every operation returns the old memory word. Compare-and-swap also returns a zero flag and the updated comparison register.

Top module: `locked_rmw_unit`

## Requirements
- R1: An operation runs strictly as lock take, memory read in the following cycle, memory write (when one is due) in the cycle after that, then lock drop. `done_o` is high in the cycle after the drop. Memory is accessed only while `lock_own_o` is high. With the lock free and the buffer empty, `done_o` rises 5 cycles after the request was sampled.
- R2: `lock_take_o` pulses only when `lock_busy_i` is low and `sb_empty_i` is high. Otherwise the unit waits in its acquire step, with `lock_own_o` low and no memory access.
- R3: `lock_drop_o` pulses only when `sb_empty_i` is high, and only while the unit holds the lock. Until then `lock_own_o` stays high and `done_o` stays low.
- R4: Opcode 0 (increment) writes old+1 modulo 2^32. If another thread increments the same word while the unit waits for the lock, the final word is the start value plus 2.
- R5: Opcode 1 writes old+src, opcode 2 writes old−src, and opcode 3 writes src. Results wrap modulo 2^32.
- R6: For opcode 4 (compare-and-swap) with `req_cmp_i` equal to the old word, `zf_o` is 1, src is written, and `cmp_o` keeps the comparison value.
- R7: For opcode 4 with `req_cmp_i` different from the old word, `zf_o` is 0, memory is not written, and `cmp_o` returns the old word.
- R8: `old_o` returns the old memory word for every opcode. For every opcode other than 4, `zf_o` is 0 and `cmp_o` equals `req_cmp_i`.
- R9: `done_o` is high for exactly one cycle. `old_o`, `zf_o` and `cmp_o` stay unchanged until the next completion.
- R10: A request is taken only while `busy_o` is low. `req_valid_i` asserted while busy has no effect on memory and starts no further lock sequence.
- R11: Opcodes 5 to 7 run the full lock sequence and return the old word, but write nothing and give `zf_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Opcode (0 inc, 1 add, 2 sub, 3 xchg, 4 cas) |
| req_addr_i | input | ADDR_W | Target word address |
| req_src_i | input | DATA_W | Source operand |
| req_cmp_i | input | DATA_W | Comparison register value |
| busy_o | output | 1 | Unit is not idle |
| lock_busy_i | input | 1 | Global lock held by another thread |
| sb_empty_i | input | 1 | Requester's store buffer is empty |
| lock_take_o | output | 1 | Take the global lock this cycle |
| lock_drop_o | output | 1 | Release the global lock this cycle |
| lock_own_o | output | 1 | Unit holds the global lock |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_wr_en_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the read strobe |
| done_o | output | 1 | Completion pulse |
| old_o | output | DATA_W | Old memory word |
| zf_o | output | 1 | Compare-and-swap zero flag |
| cmp_o | output | DATA_W | Comparison register result |

## Verification
All eight opcodes are swept against old words that include zero, one, all-ones and the signed boundaries. Each run pairs a matching and a non-matching comparison value, so carries, borrows and wraparound are exercised. The same runs separate the compare-and-swap write and no-write paths. Separate patterns hold the lock with another thread, hold the store buffer non-empty before the take and again before the drop, and present requests while busy. Together these show that waiting delays the sequence without losing the update. Another thread's increment made during the wait separates a correct atomic increment from a lost update.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OPC_INC  = 3'd0;
  localparam logic [OP_W-1:0] OPC_ADD  = 3'd1;
  localparam logic [OP_W-1:0] OPC_SUB  = 3'd2;
  localparam logic [OP_W-1:0] OPC_XCHG = 3'd3;
  localparam logic [OP_W-1:0] OPC_CAS  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACQUIRE = 3'd1,
    ST_READ    = 3'd2,
    ST_WRITE   = 3'd3,
    ST_RELEASE = 3'd4,
    ST_DONE    = 3'd5
  } rmw_state_e;
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] new_o,
  output logic              wr_o,
  output logic              zf_o,
  output logic [DATA_W-1:0] cmp_res_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] f_sum(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] f_diff(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic f_hit(input logic [DATA_W-1:0] a,
                                 input logic [DATA_W-1:0] b);
    return a == b;
  endfunction

  logic hit;
  assign hit = f_hit(cmp_i, old_i);

  always_comb begin
    new_o     = old_i;
    wr_o      = 1'b0;
    zf_o      = 1'b0;
    cmp_res_o = cmp_i;
    unique case (op_i)
      OPC_INC:  begin new_o = f_sum(old_i, ONE);   wr_o = 1'b1; end
      OPC_ADD:  begin new_o = f_sum(old_i, src_i); wr_o = 1'b1; end
      OPC_SUB:  begin new_o = f_diff(old_i, src_i); wr_o = 1'b1; end
      OPC_XCHG: begin new_o = src_i;               wr_o = 1'b1; end
      OPC_CAS: begin
        zf_o = hit;
        if (hit) begin
          new_o = src_i;
          wr_o  = 1'b1;
        end else begin
          cmp_res_o = old_i;
        end
      end
      default: begin
        new_o = old_i;
        wr_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rmw_lock_gate.sv
module rmw_lock_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_busy_i,
  input  logic sb_empty_i,
  input  logic want_take_i,
  input  logic want_drop_i,
  output logic take_o,
  output logic drop_o,
  output logic own_o
);
  logic own_q;

  // Take: lock free, buffer drained, not already ours.
  assign take_o = want_take_i & ~own_q & ~lock_busy_i & sb_empty_i;
  // Drop: only the holder, only with a drained buffer.
  assign drop_o = want_drop_i & own_q & sb_empty_i;
  assign own_o  = own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= 1'b0;
    else if (take_o) own_q <= 1'b1;
    else if (drop_o) own_q <= 1'b0;
  end
endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic take_i,
  input  logic drop_i,
  output logic accept_o,
  output logic want_take_o,
  output logic want_drop_o,
  output logic rd_phase_o,
  output logic wr_phase_o,
  output logic done_o,
  output logic busy_o
);
  rmw_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_valid_i) st_d = ST_ACQUIRE;
      ST_ACQUIRE: if (take_i)      st_d = ST_READ;
      ST_READ:                     st_d = ST_WRITE;
      ST_WRITE:                    st_d = ST_RELEASE;
      ST_RELEASE: if (drop_i)      st_d = ST_DONE;
      ST_DONE:                     st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign accept_o    = (st_q == ST_IDLE) & req_valid_i;
  assign want_take_o = (st_q == ST_ACQUIRE);
  assign want_drop_o = (st_q == ST_RELEASE);
  assign rd_phase_o  = (st_q == ST_READ);
  assign wr_phase_o  = (st_q == ST_WRITE);
  assign done_o      = (st_q == ST_DONE);
  assign busy_o      = (st_q != ST_IDLE);
endmodule

// File: rtl/locked_rmw_unit.sv
module locked_rmw_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_src_i,
  input  logic [DATA_W-1:0] req_cmp_i,
  output logic              busy_o,
  input  logic              lock_busy_i,
  input  logic              sb_empty_i,
  output logic              lock_take_o,
  output logic              lock_drop_o,
  output logic              lock_own_o,
  output logic              mem_rd_en_o,
  output logic              mem_wr_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] old_o,
  output logic              zf_o,
  output logic [DATA_W-1:0] cmp_o
);
  // Named internal events
  logic accept, want_take, want_drop, rd_phase, wr_phase;
  logic alu_wr, alu_zf;
  logic [DATA_W-1:0] alu_new, alu_cmp;

  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, cmp_q;
  logic [DATA_W-1:0] old_q, cmpres_q;
  logic              zf_q;

  rmw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .take_i     (lock_take_o),
    .drop_i     (lock_drop_o),
    .accept_o   (accept),
    .want_take_o(want_take),
    .want_drop_o(want_drop),
    .rd_phase_o (rd_phase),
    .wr_phase_o (wr_phase),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  rmw_lock_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_busy_i(lock_busy_i),
    .sb_empty_i (sb_empty_i),
    .want_take_i(want_take),
    .want_drop_i(want_drop),
    .take_o     (lock_take_o),
    .drop_o     (lock_drop_o),
    .own_o      (lock_own_o)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i     (op_q),
    .old_i    (mem_rdata_i),
    .src_i    (src_q),
    .cmp_i    (cmp_q),
    .new_o    (alu_new),
    .wr_o     (alu_wr),
    .zf_o     (alu_zf),
    .cmp_res_o(alu_cmp)
  );

  // Request capture, only in idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      src_q  <= '0;
      cmp_q  <= '0;
    end else if (accept) begin
      op_q   <= req_op_i;
      addr_q <= req_addr_i;
      src_q  <= req_src_i;
      cmp_q  <= req_cmp_i;
    end
  end

  // Results captured in the write step, held until the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q    <= '0;
      zf_q     <= 1'b0;
      cmpres_q <= '0;
    end else if (wr_phase) begin
      old_q    <= mem_rdata_i;
      zf_q     <= alu_zf;
      cmpres_q <= alu_cmp;
    end
  end

  assign mem_rd_en_o = rd_phase;
  assign mem_wr_en_o = wr_phase & alu_wr;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = alu_new;
  assign old_o       = old_q;
  assign zf_o        = zf_q;
  assign cmp_o       = cmpres_q;
endmodule

// File: rtl/rmw_checker.sv
module rmw_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid_i,
  input logic busy_o,
  input logic lock_busy_i,
  input logic sb_empty_i,
  input logic lock_take_o,
  input logic lock_drop_o,
  input logic lock_own_o,
  input logic mem_rd_en_o,
  input logic mem_wr_en_o,
  input logic done_o
);
  // R1: read follows the take by one cycle
  a_r1_read_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    lock_take_o |=> mem_rd_en_o);
  // R1: memory touched only while holding the lock
  a_r1_access_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en_o || mem_wr_en_o) |-> lock_own_o);
  // R1: completion follows the drop
  a_r1_done_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    lock_drop_o |=> done_o);
  // R2: take only with lock free and buffer empty
  a_r2_take_guard: assert property (@(posedge clk) disable iff (!rst_n)
    lock_take_o |-> (!lock_busy_i && sb_empty_i && !lock_own_o));
  // R2: ownership appears only through a take
  a_r2_own_from_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_own_o) |-> $past(lock_take_o));
  // R3: drop only by the holder with an empty buffer
  a_r3_drop_guard: assert property (@(posedge clk) disable iff (!rst_n)
    lock_drop_o |-> (sb_empty_i && lock_own_o));
  // R3: ownership ends only through a drop
  a_r3_own_to_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_own_o) |-> $past(lock_drop_o));
  // R9: single-cycle completion
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: leaving idle needs a request
  a_r10_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_valid_i));
  // R1: at most one of take and drop
  a_r1_take_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_take_o, lock_drop_o}));
endmodule

bind locked_rmw_unit rmw_checker u_rmw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .busy_o     (busy_o),
  .lock_busy_i(lock_busy_i),
  .sb_empty_i (sb_empty_i),
  .lock_take_o(lock_take_o),
  .lock_drop_o(lock_drop_o),
  .lock_own_o (lock_own_o),
  .mem_rd_en_o(mem_rd_en_o),
  .mem_wr_en_o(mem_wr_en_o),
  .done_o     (done_o)
);

// File: tb/test_locked_rmw_unit.sv
`timescale 1ns/1ps
module test_locked_rmw_unit;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_src = '0, req_cmp = '0;
  logic          busy_o, lock_take, lock_drop, lock_own;
  logic          other_hold = 1'b0, sb_empty = 1'b1;
  logic          mem_rd, mem_wr, done_o, zf_o;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0, old_o, cmp_o;

  logic          ext_we = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [DW-1:0] ext_data = '0;
  logic [DW-1:0] mem [256];

  int n_tests = 0, n_fail = 0, viol = 0, takes = 0, cycles = 0;
  logic [DW-1:0] vals [6];

  locked_rmw_unit #(.DATA_W(DW), .ADDR_W(AW)) i_locked_rmw_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_src_i(req_src), .req_cmp_i(req_cmp), .busy_o(busy_o),
    .lock_busy_i(other_hold), .sb_empty_i(sb_empty),
    .lock_take_o(lock_take), .lock_drop_o(lock_drop), .lock_own_o(lock_own),
    .mem_rd_en_o(mem_rd), .mem_wr_en_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done_o), .old_o(old_o), .zf_o(zf_o), .cmp_o(cmp_o)
  );

  // Shared memory model with one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (ext_we) mem[ext_addr] <= ext_data;
  end

  // Protocol monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (lock_take && (other_hold || !sb_empty)) viol++;
      if (lock_drop && !sb_empty) viol++;
      if ((mem_rd || mem_wr) && !lock_own) viol++;
      if (lock_take) takes++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [DW-1:0] exp_mem(input int op, input logic [DW-1:0] old,
                                            input logic [DW-1:0] src,
                                            input logic [DW-1:0] cmp);
    case (op)
      0: return old + 32'd1;
      1: return old + src;
      2: return old - src;
      3: return src;
      4: return (cmp == old) ? src : old;
      default: return old;
    endcase
  endfunction

  task automatic set_mem(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ext_we = 1'b1; ext_addr = a; ext_data = d;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic start_req(input int op, input logic [AW-1:0] a,
                           input logic [DW-1:0] s, input logic [DW-1:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_op = op[2:0]; req_addr = a; req_src = s; req_cmp = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done_o && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int cyc;
    logic [DW-1:0] held;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
    for (int i = 0; i < 256; i++) mem[i] = '0;

    repeat (3) @(negedge clk);
    // Reset state
    chk(!busy_o && !lock_own && !done_o, "R10 reset idle", {29'd0, busy_o, lock_own, done_o}, 0);
    chk(!mem_rd && !mem_wr && !lock_take, "R1 reset no access", {30'd0, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;

    // Sweep over every opcode, old word and comparison variant
    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < 6; i++) begin
        for (int k = 0; k < 2; k++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] old, src, cmp, e;
          a   = AW'(op * 8 + i);
          old = vals[i];
          src = vals[(i + k + 1) % 6];
          cmp = (k == 0) ? old : (old ^ 32'h5A5A_0001);
          e   = exp_mem(op, old, src, cmp);
          set_mem(a, old);
          start_req(op, a, src, cmp);
          wait_done(cyc);
          chk(cyc == 5, "R1 latency", DW'(cyc), 5);
          chk(old_o == old, "R8 old value", old_o, old);
          case (op)
            0: chk(mem[a] == e, "R4 increment", mem[a], e);
            1, 2, 3: chk(mem[a] == e, "R5 add/sub/xchg", mem[a], e);
            4: begin
              if (k == 0) begin
                chk(mem[a] == e, "R6 cas match write", mem[a], e);
                chk(zf_o == 1'b1, "R6 cas zf", DW'(zf_o), 1);
                chk(cmp_o == cmp, "R6 cas cmp kept", cmp_o, cmp);
              end else begin
                chk(mem[a] == old, "R7 cas miss no write", mem[a], old);
                chk(zf_o == 1'b0, "R7 cas zf", DW'(zf_o), 0);
                chk(cmp_o == old, "R7 cas cmp loaded", cmp_o, old);
              end
            end
            default: begin
              chk(mem[a] == old, "R11 no write", mem[a], old);
              chk(zf_o == 1'b0, "R11 zf", DW'(zf_o), 0);
            end
          endcase
          if (op != 4) begin
            chk(zf_o == 1'b0, "R8 zf clear", DW'(zf_o), 0);
            chk(cmp_o == cmp, "R8 cmp pass", cmp_o, cmp);
          end
          held = old_o;
          @(negedge clk);
          chk(!done_o, "R9 done pulse", DW'(done_o), 0);
          chk(old_o == held, "R9 result held", old_o, held);
        end
      end
    end

    // R4 / R2: another thread holds the lock and increments first
    other_hold = 1'b1;
    set_mem(8'd200, 32'd0);
    start_req(0, 8'd200, 32'd0, 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk(!lock_own && !done_o, "R2 wait on held lock", DW'(lock_own), 0);
    end
    set_mem(8'd200, mem[200] + 32'd1);
    other_hold = 1'b0;
    wait_done(cyc);
    chk(mem[200] == 32'd2, "R4 no lost update", mem[200], 2);
    chk(old_o == 32'd1, "R4 saw other increment", old_o, 1);
    @(negedge clk);

    // R2: store buffer not empty before take
    sb_empty = 1'b0;
    set_mem(8'd201, 32'd10);
    start_req(1, 8'd201, 32'd5, 32'd0);
    repeat (4) begin
      @(negedge clk);
      chk(!lock_own && !mem_rd, "R2 wait on buffer", DW'(lock_own), 0);
    end
    sb_empty = 1'b1;
    wait_done(cyc);
    chk(mem[201] == 32'd15, "R2 completes after drain", mem[201], 15);
    @(negedge clk);

    // R3: store buffer not empty before drop
    set_mem(8'd202, 32'd7);
    start_req(2, 8'd202, 32'd9, 32'd0);
    @(negedge clk);
    @(negedge clk);
    sb_empty = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(lock_own && !done_o, "R3 hold until drained", DW'(lock_own), 1);
    end
    sb_empty = 1'b1;
    wait_done(cyc);
    chk(mem[202] == 32'hFFFF_FFFE, "R3 result after drain", mem[202], 32'hFFFF_FFFE);
    @(negedge clk);
    chk(!lock_own, "R3 lock released", DW'(lock_own), 0);

    // R10: requests while busy are ignored
    set_mem(8'd210, 32'd5);
    takes = 0;
    start_req(0, 8'd210, 32'd0, 32'd0);
    req_valid = 1'b1; req_op = 3'd3; req_addr = 8'd210; req_src = 32'd99;
    chk(busy_o, "R10 busy during op", DW'(busy_o), 1);
    wait_done(cyc);
    req_valid = 1'b0;
    chk(mem[210] == 32'd6, "R10 busy request ignored", mem[210], 6);
    repeat (8) @(negedge clk);
    chk(takes == 1 && !busy_o, "R10 single lock sequence", DW'(takes), 1);

    chk(viol == 0, "R1 R2 R3 protocol monitor", DW'(viol), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule